// File: doc/BRIEF.md
# Windowed Pulse Feature Extractor

This block turns a stream of raw detector samples into a short set of pulse parameters. Only the samples that fall inside a search window are used. The window is placed at a signed offset from a trigger. The block condenses those samples into seven tagged result words, so downstream logic does not have to move every raw sample.

The words are:

- the window offset;
- the peak height above the baseline;
- the charge (a sum over an integration window);
- the raw mean of the four samples just before the window;
- the raw mean of the four samples just after it;
- the arrival time in quarter-sample steps;
- the time of the first sample in the window that lies above the baseline.

Samples enter on a valid/ready stream. One input flag marks the sample that defines time zero. Samples are delayed internally by a fixed history of D = 2^(OW-1)+4 entries (20 with the defaults). This lets the window begin before the trigger. At least D samples must have been accepted before a trigger so that this history is filled.

Results leave on a second valid/ready stream. The input side is back-pressured, with `s_ready` held low, from the cycle results become valid until the last result word has been taken. The output side holds each word until `m_ready` accepts it.

Top module: `pulse_feature_extractor`

## Requirements
- R1: A trigger (sample accepted with `s_trig`=1) starts a capture only when the block is idle, `int_len` >= 4 and `win_len` >= 1. A trigger with a shorter integration length produces no done pulse and no result words. A trigger flag on any sample accepted during a capture has no effect.
- R2: The trigger sample has time 0; later samples count up and earlier ones count down. The window covers times ws..ws+wl-1, where ws is the signed `win_start`. The pre-samples are ws-4..ws-1 and the post-samples are ws+wl..ws+wl+3. Word 0 carries ws.
- R3: The amplitude is the largest value of (sample - baseline) inside the window, as a signed number. On ties the earliest sample is the peak.
- R4: The integral is the signed sum of (sample - baseline) over the first min(int_len, win_len) window samples.
- R5: The pre-mean and post-mean are floor(sum/4) of the four raw pre-samples and the four raw post-samples respectively.
- R6: The first-positive time is the time of the earliest window sample with sample - baseline > 0. If there is none, it is ws+wl.
- R7: Let x = sample - baseline. Let d be the largest rise x(t)-x(t-1) over window times t up to the peak, earliest on ties; x(t-1) may be the last pre-sample. Let k be its time. If d > 0, the arrival is 4k - c, where c counts the m in 1..15 with m*d <= 4*x(k). Otherwise the arrival is 4 times the peak time. The unit is a quarter sample period.
- R8: `done` is high for exactly one cycle, the cycle after the handshake that consumes post-sample ws+wl+3. With a D-deep history, that handshake is the one that accepts the sample of time ws+wl+3+D. `m_valid` rises in the same cycle.
- R9: There are seven result words, emitted in order. Each is {tag[7:0], value[23:0]}: the tag is 0xA0 plus the word index and the value is sign-extended. The order is: offset, amplitude, integral, pre-mean, post-mean, arrival, first-positive. While `m_ready` is low, `m_valid` and `m_data` hold.
- R10: `s_ready` is low exactly while results are pending. After the seventh word is accepted, `m_valid` falls and `s_ready` returns high in the next cycle.
- R11: After reset, `s_ready` is 1, and `m_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_data | input | DW | Raw unsigned sample |
| s_trig | input | 1 | Marks the accompanying sample as time 0 |
| baseline | input | DW | Pedestal level, latched at trigger |
| win_start | input | OW | Signed window offset in samples |
| win_len | input | LW | Window length in samples |
| int_len | input | LW | Integration length in samples |
| m_valid | output | 1 | Result word valid |
| m_ready | input | 1 | Result word accepted |
| m_data | output | 8+VW | Tagged result word |
| done | output | 1 | One-cycle pulse when results become valid |

## Verification
Two events are made to meet. In one, the handshake that consumes the final post-sample also carries a fresh trigger flag, so leaving the capture and a would-be restart fall in one cycle. In the other, an integration length longer than the window has the charge sum closing on the same sample as the window itself. The reference model expects the extra trigger to be dropped: exactly one done pulse is expected, then the idle state again. It also expects the integral to stop at the window end. Both are judged on the result words and on the per-cycle `done` and `s_ready` values under output back-pressure.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CAP, ST_EMIT} fx_state_e;
  localparam int NWORDS = 7;
  localparam logic [7:0] TAG_BASE = 8'hA0;
endpackage

// File: rtl/fx_window_timer.sv
module fx_window_timer #(
  parameter int OW = 5,
  parameter int LW = 6,
  parameter int TW = 9,
  parameter int D  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 adv,
  input  logic signed [OW-1:0] ws,
  input  logic        [LW-1:0] wl,
  output logic signed [TW-1:0] pt,
  output logic signed [TW-1:0] rel,
  output logic                 ph_pre,
  output logic                 ph_win,
  output logic                 ph_post,
  output logic                 ph_last
);
  localparam logic signed [TW-1:0] PT_INIT = TW'(-D);
  localparam logic signed [TW-1:0] NEG4    = TW'(-4);

  logic signed [TW-1:0] pt_q, wsx, wlx, wl3, wl4;

  assign wsx = TW'(ws);
  assign wlx = $signed({{(TW-LW){1'b0}}, wl});
  assign wl3 = wlx + TW'(3);
  assign wl4 = wlx + TW'(4);

  // time of the sample leaving the history in this cycle
  assign pt  = start ? PT_INIT : pt_q;
  assign rel = pt - wsx;

  assign ph_pre  = (rel >= NEG4) && (rel < TW'(0));
  assign ph_win  = (rel >= TW'(0)) && (rel < wlx);
  assign ph_post = (rel >= wlx) && (rel < wl4);
  assign ph_last = (rel == wl3);

  always_ff @(posedge clk) begin
    if (!rst_n) pt_q <= PT_INIT;
    else if (adv) pt_q <= pt + TW'(1);
  end
endmodule

// File: rtl/fx_accum.sv
module fx_accum #(
  parameter int DW = 12,
  parameter int LW = 6,
  parameter int TW = 9,
  localparam int XW = DW + 1,
  localparam int IW = XW + LW,
  localparam int SW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 ph_pre,
  input  logic                 ph_win,
  input  logic                 ph_post,
  input  logic signed [TW-1:0] rel,
  input  logic        [LW-1:0] il,
  input  logic        [DW-1:0] raw,
  input  logic signed [XW-1:0] x,
  output logic signed [IW-1:0] integ,
  output logic        [SW-1:0] pre_sum,
  output logic        [SW-1:0] post_sum
);
  logic signed [TW-1:0] ilx;
  logic in_int;

  assign ilx    = $signed({{(TW-LW){1'b0}}, il});
  assign in_int = ph_win && (rel < ilx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ    <= '0;
      pre_sum  <= '0;
      post_sum <= '0;
    end else if (en) begin
      integ    <= (clr ? IW'(0) : integ) + (in_int ? IW'(x) : IW'(0));
      pre_sum  <= (clr ? SW'(0) : pre_sum) + (ph_pre ? SW'(raw) : SW'(0));
      post_sum <= (clr ? SW'(0) : post_sum) + (ph_post ? SW'(raw) : SW'(0));
    end
  end
endmodule

// File: rtl/fx_peak_edge.sv
module fx_peak_edge #(
  parameter int XW   = 13,
  parameter int TW   = 9,
  parameter int QCAP = 15,
  localparam int AW  = TW + 2,
  localparam int MW  = XW + 8,
  localparam int QW  = $clog2(QCAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 ph_win,
  input  logic signed [TW-1:0] pt,
  input  logic signed [XW-1:0] x,
  output logic signed [XW-1:0] amp,
  output logic signed [TW-1:0] t_pk,
  output logic                 fp_found,
  output logic signed [TW-1:0] fp_t,
  output logic signed [AW-1:0] arrival
);
  logic signed [XW-1:0] prev_x, rb_x, cm_x, c_x;
  logic signed [XW:0]   rise, rb_d, cm_d, c_d;
  logic signed [TW-1:0] rb_k, cm_k, c_k;
  logic amp_vld, rb_vld, take_rise, new_pk;

  assign rise      = XW'(x) - XW'(prev_x) == 0 ? '0 : (XW+1)'(x) - (XW+1)'(prev_x);
  assign take_rise = !rb_vld || (rise > rb_d);
  assign c_d       = take_rise ? rise : rb_d;
  assign c_k       = take_rise ? pt   : rb_k;
  assign c_x       = take_rise ? x    : rb_x;
  assign new_pk    = !amp_vld || (x > amp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_x <= '0; amp <= '0; t_pk <= '0; amp_vld <= 1'b0;
      rb_d <= '0; rb_k <= '0; rb_x <= '0; rb_vld <= 1'b0;
      cm_d <= '0; cm_k <= '0; cm_x <= '0;
      fp_found <= 1'b0; fp_t <= '0;
    end else if (en) begin
      prev_x <= x;
      if (clr) begin
        amp_vld  <= 1'b0;
        rb_vld   <= 1'b0;
        fp_found <= 1'b0;
      end else if (ph_win) begin
        rb_d <= c_d; rb_k <= c_k; rb_x <= c_x; rb_vld <= 1'b1;
        if (new_pk) begin
          amp <= x; t_pk <= pt; amp_vld <= 1'b1;
          cm_d <= c_d; cm_k <= c_k; cm_x <= c_x;
        end
        if (!fp_found && (x > XW'(0))) begin
          fp_found <= 1'b1;
          fp_t     <= pt;
        end
      end
    end
  end

  // quarter-step extrapolation down to the pedestal: count m*d <= 4*x
  logic signed [MW-1:0] num, dx;
  logic [QCAP-1:0] ge;
  logic [QW-1:0]   q;

  assign num = MW'(cm_x) <<< 2;
  assign dx  = MW'(cm_d);

  for (genvar m = 1; m <= QCAP; m++) begin : g_step
    assign ge[m-1] = (cm_d > 0) && ((dx * $signed(MW'(m))) <= num);
  end

  always_comb begin
    q = '0;
    for (int i = 0; i < QCAP; i++) q = q + QW'(ge[i]);
  end

  assign arrival = (cm_d > 0) ? ((AW'(cm_k) <<< 2) - $signed(AW'(q)))
                              : (AW'(t_pk) <<< 2);

  p_amp_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_win && !clr && amp_vld) |=> (amp >= $past(amp)));
endmodule

// File: rtl/pulse_feature_extractor.sv
module pulse_feature_extractor #(
  parameter int DW   = 12,
  parameter int OW   = 5,
  parameter int LW   = 6,
  parameter int VW   = 24,
  parameter int QCAP = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_data,
  input  logic                 s_trig,
  input  logic [DW-1:0]        baseline,
  input  logic signed [OW-1:0] win_start,
  input  logic [LW-1:0]        win_len,
  input  logic [LW-1:0]        int_len,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [7+VW:0]        m_data,
  output logic                 done
);
  import fx_pkg::*;

  localparam int D  = 2 ** (OW - 1) + 4;
  localparam int TW = ((OW > LW) ? OW : LW) + 3;
  localparam int XW = DW + 1;
  localparam int IW = XW + LW;
  localparam int SW = DW + 2;
  localparam int AW = TW + 2;

  fx_state_e state;
  logic signed [OW-1:0] ws_q, ws_c;
  logic [LW-1:0] wl_q, il_q, wl_c, il_c;
  logic [DW-1:0] bl_q, bl_c;
  logic [DW-1:0] hist [D];
  logic [2:0] widx;
  logic hs, cfg_ok, start, proc, idle;

  assign idle    = (state == ST_IDLE);
  assign s_ready = (state != ST_EMIT);
  assign m_valid = (state == ST_EMIT);
  assign hs      = s_valid && s_ready;
  assign cfg_ok  = (int_len >= LW'(4)) && (win_len != '0);
  assign start   = hs && idle && s_trig && cfg_ok;
  assign proc    = start || (hs && (state == ST_CAP));

  assign ws_c = idle ? win_start : ws_q;
  assign wl_c = idle ? win_len   : wl_q;
  assign il_c = idle ? int_len   : il_q;
  assign bl_c = idle ? baseline  : bl_q;

  // fixed history so the window may open before the trigger
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) hist[i] <= '0;
    end else if (hs) begin
      hist[0] <= s_data;
      for (int i = 1; i < D; i++) hist[i] <= hist[i-1];
    end
  end

  logic [DW-1:0] raw;
  logic signed [XW-1:0] x;
  assign raw = hist[D-1];
  assign x   = $signed({1'b0, raw}) - $signed({1'b0, bl_c});

  logic signed [TW-1:0] pt, rel;
  logic ph_pre, ph_win, ph_post, ph_last;

  fx_window_timer #(.OW(OW), .LW(LW), .TW(TW), .D(D)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(proc),
    .ws(ws_c), .wl(wl_c), .pt(pt), .rel(rel),
    .ph_pre(ph_pre), .ph_win(ph_win), .ph_post(ph_post), .ph_last(ph_last)
  );

  logic signed [IW-1:0] integ;
  logic [SW-1:0] pre_sum, post_sum;

  fx_accum #(.DW(DW), .LW(LW), .TW(TW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(proc),
    .ph_pre(ph_pre), .ph_win(ph_win), .ph_post(ph_post),
    .rel(rel), .il(il_c), .raw(raw), .x(x),
    .integ(integ), .pre_sum(pre_sum), .post_sum(post_sum)
  );

  logic signed [XW-1:0] amp;
  logic signed [TW-1:0] t_pk, fp_t;
  logic fp_found;
  logic signed [AW-1:0] arrival;

  fx_peak_edge #(.XW(XW), .TW(TW), .QCAP(QCAP)) u_peak (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(proc), .ph_win(ph_win),
    .pt(pt), .x(x), .amp(amp), .t_pk(t_pk),
    .fp_found(fp_found), .fp_t(fp_t), .arrival(arrival)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ws_q <= '0; wl_q <= '0; il_q <= '0; bl_q <= '0;
      widx <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_CAP;
          ws_q <= win_start; wl_q <= win_len; il_q <= int_len; bl_q <= baseline;
        end
        ST_CAP: if (proc && ph_last) begin
          state <= ST_EMIT;
          done  <= 1'b1;
          widx  <= '0;
        end
        ST_EMIT: if (m_ready) begin
          if (widx == 3'(NWORDS - 1)) state <= ST_IDLE;
          else widx <= widx + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic signed [TW-1:0] fp_none;
  logic [VW-1:0] val;
  assign fp_none = TW'(ws_q) + $signed({{(TW-LW){1'b0}}, wl_q});

  always_comb begin
    case (widx)
      3'd0:    val = VW'(ws_q);
      3'd1:    val = VW'(amp);
      3'd2:    val = VW'(integ);
      3'd3:    val = VW'(pre_sum[SW-1:2]);
      3'd4:    val = VW'(post_sum[SW-1:2]);
      3'd5:    val = VW'(arrival);
      default: val = fp_found ? VW'(fp_t) : VW'(fp_none);
    endcase
  end

  assign m_data = {TAG_BASE + 8'(widx), val};

  p_cfg_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAP) |-> ((il_q >= LW'(4)) && (wl_q != '0)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> m_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && (m_data[7+VW:VW] == TAG_BASE + 8'(NWORDS - 1)))
      |=> (!m_valid && s_ready));
endmodule

// File: tb/pulse_feature_extractor_bench.sv
module pulse_feature_extractor_bench;
  localparam int DW = 12, OW = 5, LW = 6, VW = 24;
  localparam int D  = 2 ** (OW - 1) + 4;

  logic clk = 0;
  logic rst_n = 0;
  logic s_valid = 0, s_trig = 0, m_ready = 0;
  logic s_ready, m_valid, done;
  logic [DW-1:0] s_data = '0, baseline = '0;
  logic signed [OW-1:0] win_start = '0;
  logic [LW-1:0] win_len = '0, int_len = '0;
  logic [7+VW:0] m_data;

  int tests = 0, fails = 0;
  logic [31:0] exp_w [7];

  always #5 clk = ~clk;

  pulse_feature_extractor u_pulse_feature_extractor (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_trig(s_trig), .baseline(baseline),
    .win_start(win_start), .win_len(win_len), .int_len(int_len),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .done(done)
  );

  task automatic chk(input bit c, input string r, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  function automatic int gen(int kind, int t, int bl);
    int v, h;
    case (kind)
      0: begin
        h = (t < 2) ? 0 : (t <= 6) ? (t - 1) * 150 : (t <= 14) ? 750 - (t - 6) * 80 : 0;
        v = bl + (((t * 7) % 5 + 5) % 5) - 2 + h;
      end
      1: v = bl;
      2: v = bl - 40 - (((t * 3) % 7 + 7) % 7);
      default: v = (t >= 0) ? bl + 300 : bl;
    endcase
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic string req_of(int i);
    case (i)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R5"; 5: return "R7"; default: return "R6";
    endcase
  endfunction

  task automatic expect_words(input int ws, wl, il, bl, kind);
    int amp, tpk, integ, pre, post, fp, bd, bk, bx, arr, cnt, n;
    amp = 0; tpk = 0; bd = 0; bk = 0; bx = 0;
    for (int t = ws; t < ws + wl; t++) begin
      int x = gen(kind, t, bl) - bl;
      if (t == ws || x > amp) begin amp = x; tpk = t; end
    end
    for (int t = ws; t <= tpk; t++) begin
      int r = (gen(kind, t, bl) - bl) - (gen(kind, t - 1, bl) - bl);
      if (t == ws || r > bd) begin bd = r; bk = t; bx = gen(kind, t, bl) - bl; end
    end
    integ = 0; n = (il < wl) ? il : wl;
    for (int t = ws; t < ws + n; t++) integ += gen(kind, t, bl) - bl;
    pre = 0; post = 0;
    for (int j = 0; j < 4; j++) begin
      pre  += gen(kind, ws - 4 + j, bl);
      post += gen(kind, ws + wl + j, bl);
    end
    fp = ws + wl;
    for (int t = ws + wl - 1; t >= ws; t--) if (gen(kind, t, bl) - bl > 0) fp = t;
    if (bd > 0) begin
      cnt = 0;
      for (int m = 1; m <= 15; m++) if (m * bd <= 4 * bx) cnt++;
      arr = 4 * bk - cnt;
    end else arr = 4 * tpk;
    exp_w[0] = {8'hA0, 24'(ws)};
    exp_w[1] = {8'hA1, 24'(amp)};
    exp_w[2] = {8'hA2, 24'(integ)};
    exp_w[3] = {8'hA3, 24'(pre / 4)};
    exp_w[4] = {8'hA4, 24'(post / 4)};
    exp_w[5] = {8'hA5, 24'(arr)};
    exp_w[6] = {8'hA6, 24'(fp)};
  endtask

  // cycle-level reference model: one sample stream, one result stream
  task automatic run_case(input int ws, wl, il, bl, kind, mr, xt);
    int t_next = -24, mst = 0, widx = 0, dseen = 0, cyc = 0;
    bit exp_done = 0, fin = 0;
    bit ok = (il >= 4) && (wl >= 1);
    int last_in = ws + wl + 3 + D;
    int stop_t = ok ? 1000 : 12;
    expect_words(ws, wl, il, bl, kind);
    win_start = OW'(ws); win_len = LW'(wl); int_len = LW'(il); baseline = DW'(bl);
    while (!fin) begin
      @(negedge clk);
      cyc++;
      chk(done === exp_done, "R8 done", 32'(done), 32'(exp_done));
      chk(s_ready === (mst != 2), "R10 s_ready", 32'(s_ready), 32'(mst != 2));
      if (mst == 2) begin
        chk(m_valid === 1'b1, "R9 m_valid", 32'(m_valid), 32'd1);
        chk(m_data === exp_w[widx], req_of(widx), m_data, exp_w[widx]);
      end else begin
        chk(m_valid === 1'b0, "R9 m_valid", 32'(m_valid), 32'd0);
      end
      if (done === 1'b1) dseen++;
      s_valid = (mst != 2) && (t_next <= stop_t) && ((cyc % 4) != 3);
      s_data  = DW'(gen(kind, t_next, bl));
      s_trig  = (t_next == 0) || (xt != 0 && (t_next == 5 || t_next == last_in));
      m_ready = (mr != 0) ? ((cyc % 3) != 1) : 1'b1;
      @(posedge clk);
      exp_done = 0;
      if (mst == 2) begin
        if (m_ready) begin
          widx++;
          if (widx == 7) begin mst = 0; fin = 1; end
        end
      end else if (s_valid) begin
        if (mst == 0 && t_next == 0 && ok) mst = 1;
        if (mst == 1 && t_next - D == ws + wl + 3) begin mst = 2; exp_done = 1; end
        t_next++;
      end
      if (!ok && t_next > stop_t) fin = 1;
    end
    chk(dseen == (ok ? 1 : 0), "R1 done count", 32'(dseen), 32'(ok ? 1 : 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R11 s_ready", 32'(s_ready), 32'd1);
    chk(m_valid === 1'b0, "R11 m_valid", 32'(m_valid), 32'd0);
    chk(done === 1'b0, "R11 done", 32'(done), 32'd0);
    run_case(-2, 20, 8, 500, 0, 0, 0);    // R3 R4 R7 pulse
    run_case(-16, 24, 30, 800, 0, 1, 1);  // R2 R4 R1: earliest window, long integral, retriggers
    run_case(-3, 8, 4, 300, 3, 0, 0);     // R7 step edge, R1 minimum integration length
    run_case(0, 12, 6, 1000, 1, 1, 0);    // R6 flat: no positive sample
    run_case(-5, 15, 5, 2000, 2, 0, 0);   // R3 negative amplitude
    run_case(0, 10, 3, 600, 0, 0, 0);     // R1 rejected trigger
    run_case(15, 63, 63, 400, 0, 1, 1);   // R2 R8 latest, longest window
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule